// File: doc/BRIEF.md
# Vector Instruction Issue Controller

This block sits between the fetch stage and the execution units of a small DSP core. It takes in one 16-bit instruction word at a time and sorts it into one of three classes: a scalar (normal) instruction, a vector instruction, or an accelerator command. Scalar words go to the ALU as an issue strobe. Accelerator words leave as a command that carries a unit number and a 10-bit argument. A vector word starts a multi-cycle operation in the vector unit. That unit walks through the elements two at a time and drives the operation and port selects to the datapath until the vector is used up.

Scalar and accelerator instructions keep issuing while a vector operation runs, so control code can hide behind a long vector. Synchronisation happens at only two points. The first is an explicit IDLE instruction, which holds issue until the named unit reports done; that unit is either the vector unit or one accelerator. The second is a new vector instruction arriving while the vector unit still has more than its last pair of elements left to process. Either case raises a combinational stall toward fetch, which must hold its word until the stall drops.

Top module: `vec_issue_top`

## Requirements
- R1: A word with bit 15 = 0 that is not an IDLE is a scalar instruction. It is accepted without stall, and in the next cycle `aluIssue` pulses for one cycle with `aluWord` equal to bits 14:0 of the word.
- R2: A word with bits 15:14 = 2'b11 is an accelerator command. It is accepted without stall, and in the next cycle `accCmdValid` pulses with `accCmdUnit` = bits 13:10 and `accCmdArg` = bits 9:0.
- R3: A word with bits 15:14 = 2'b10 is a vector instruction with operation in bits 13:10, port select in bits 9:7 and element count N in bits 6:0. While its operation runs, `vecOp` and `vecPorts` carry those fields.
- R4: An accepted vector instruction on an idle unit raises `vecBusy` in the next cycle. `vecBusy` stays high for max(1, ceil(N/2)) cycles.
- R5: In busy cycle k (counting from 0), `vecElemStrobe` is high with `vecElemIdx` = 2k and `vecElemCnt` = min(2, N-2k) while 2k < N. An N of 0 gives one busy cycle and no strobe.
- R6: Scalar and accelerator words are never stalled, including while `vecBusy` is high.
- R7: A vector word stalls while the running operation has more than two elements left. It is accepted in the operation's final busy cycle, and its first strobe follows in the next cycle with `vecBusy` staying high throughout.
- R8: IDLE on the vector unit is encoded as bits 15:11 = 5'b01111 with bit 4 = 0. It stalls while `vecBusy` is high, and when accepted it issues nothing.
- R9: IDLE on an accelerator is encoded as bits 15:11 = 5'b01111 with bit 4 = 1 and the unit number in bits 3:0. It stalls while `accelDone[unit]` is low, ignores the other done bits, and issues nothing.
- R10: During and right after reset, `instrStall`, `aluIssue`, `accCmdValid`, `vecBusy` and `vecElemStrobe` are low.
- R11: When `instrValid` is low, `instrStall` is low and the word is ignored: nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Fetch presents a word |
| instrWord | input | 16 | Instruction word |
| instrStall | output | 1 | Hold the current word (combinational) |
| accelDone | input | 16 | Per-accelerator done level |
| aluIssue | output | 1 | Scalar instruction issue pulse |
| aluWord | output | 15 | Scalar instruction body |
| accCmdValid | output | 1 | Accelerator command pulse |
| accCmdUnit | output | 4 | Target accelerator |
| accCmdArg | output | 10 | Accelerator command argument |
| vecBusy | output | 1 | Vector operation in progress |
| vecOp | output | 4 | Vector operation select |
| vecPorts | output | 3 | Vector port select |
| vecElemStrobe | output | 1 | Element pair valid this cycle |
| vecElemIdx | output | 7 | Index of first element in this cycle |
| vecElemCnt | output | 2 | Elements processed this cycle (1 or 2) |

## Verification
The tests drive vectors of size 0, 1, 7 (odd, so the last cycle holds a single element) and 127. This separates rounding of the cycle count from the zero-size special case and from the wrap of the element index. One vector is followed at once by a scalar word, an accelerator word and an IDLE on the vector unit. This shows that only the IDLE waits, and that it waits exactly until busy falls. Two vectors are issued back to back to check the early acceptance in the last busy cycle and the unbroken busy run. An IDLE on one accelerator is released only by its own done bit, with a neighbouring done bit already high.

// File: rtl/vec_issue_pkg.sv
package vec_issue_pkg;
  localparam int INSTR_W  = 16;
  localparam int OP_W     = 4;
  localparam int PORT_W   = 3;
  localparam int SIZE_W   = 7;
  localparam int ACC_W    = 4;
  localparam int ACC_ARG_W = 10;
  localparam int NUM_ACC  = 1 << ACC_W;

  // control -> datapath launch strobe
  typedef struct packed {
    logic              start;
    logic [OP_W-1:0]   op;
    logic [PORT_W-1:0] ports;
    logic [SIZE_W-1:0] size;
  } vecLaunch_t;

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_IDLE   = 2'd1,
    CLS_VECTOR = 2'd2,
    CLS_ACCEL  = 2'd3
  } instrClass_t;
endpackage

// File: rtl/vec_issue_ctrl.sv
module vec_issue_ctrl
  import vec_issue_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrValid,
  input  logic [INSTR_W-1:0]   instrWord,
  input  logic [NUM_ACC-1:0]   accelDone,
  input  logic                 vecBusy,
  input  logic                 vecFree,
  output logic                 instrStall,
  output vecLaunch_t           launch,
  output logic                 aluIssue,
  output logic [INSTR_W-2:0]   aluWord,
  output logic                 accCmdValid,
  output logic [ACC_W-1:0]     accCmdUnit,
  output logic [ACC_ARG_W-1:0] accCmdArg
);
  localparam int IDLE_OP_HI = INSTR_W - 2;
  localparam int IDLE_OP_LO = INSTR_W - 5;

  instrClass_t cls;
  logic        blocked;
  logic        accept;
  logic        idleOnAcc;
  logic [ACC_W-1:0] idleUnit;

  assign idleOnAcc = instrWord[ACC_W];
  assign idleUnit  = instrWord[ACC_W-1:0];

  always_comb begin
    if (!instrWord[INSTR_W-1]) begin
      cls = (&instrWord[IDLE_OP_HI:IDLE_OP_LO]) ? CLS_IDLE : CLS_NORMAL;
    end else if (instrWord[INSTR_W-2]) begin
      cls = CLS_ACCEL;
    end else begin
      cls = CLS_VECTOR;
    end
  end

  always_comb begin
    unique case (cls)
      CLS_VECTOR: blocked = !vecFree;
      CLS_IDLE:   blocked = idleOnAcc ? !accelDone[idleUnit] : vecBusy;
      default:    blocked = 1'b0;
    endcase
  end

  assign instrStall = instrValid && blocked;
  assign accept     = instrValid && !blocked;

  always_comb begin
    launch.start = accept && (cls == CLS_VECTOR);
    launch.op    = instrWord[INSTR_W-3 -: OP_W];
    launch.ports = instrWord[INSTR_W-3-OP_W -: PORT_W];
    launch.size  = instrWord[SIZE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aluIssue    <= 1'b0;
      aluWord     <= '0;
      accCmdValid <= 1'b0;
      accCmdUnit  <= '0;
      accCmdArg   <= '0;
    end else begin
      aluIssue    <= accept && (cls == CLS_NORMAL);
      accCmdValid <= accept && (cls == CLS_ACCEL);
      if (accept && (cls == CLS_NORMAL)) begin
        aluWord <= instrWord[INSTR_W-2:0];
      end
      if (accept && (cls == CLS_ACCEL)) begin
        accCmdUnit <= instrWord[INSTR_W-3 -: ACC_W];
        accCmdArg  <= instrWord[ACC_ARG_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vec_issue_datapath.sv
module vec_issue_datapath
  import vec_issue_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  vecLaunch_t         launch,
  output logic               vecBusy,
  output logic               vecFree,
  output logic [OP_W-1:0]    vecOp,
  output logic [PORT_W-1:0]  vecPorts,
  output logic               vecElemStrobe,
  output logic [SIZE_W-1:0]  vecElemIdx,
  output logic [$clog2(LANES+1)-1:0] vecElemCnt
);
  localparam int CNT_W = $clog2(LANES + 1);
  localparam logic [SIZE_W-1:0] STEP = SIZE_W'(LANES);

  logic              busyQ;
  logic [SIZE_W-1:0] remQ;
  logic [SIZE_W-1:0] idxQ;
  logic [OP_W-1:0]   opQ;
  logic [PORT_W-1:0] portQ;
  logic              lastCycle;

  assign lastCycle = busyQ && (remQ <= STEP);
  assign vecFree   = !busyQ || lastCycle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      remQ  <= '0;
      idxQ  <= '0;
      opQ   <= '0;
      portQ <= '0;
    end else if (launch.start) begin
      busyQ <= 1'b1;
      remQ  <= launch.size;
      idxQ  <= '0;
      opQ   <= launch.op;
      portQ <= launch.ports;
    end else if (busyQ) begin
      if (lastCycle) begin
        busyQ <= 1'b0;
        remQ  <= '0;
      end else begin
        remQ <= remQ - STEP;
        idxQ <= idxQ + STEP;
      end
    end
  end

  assign vecBusy       = busyQ;
  assign vecOp         = opQ;
  assign vecPorts      = portQ;
  assign vecElemStrobe = busyQ && (remQ != '0);
  assign vecElemIdx    = idxQ;
  assign vecElemCnt    = (remQ >= STEP) ? CNT_W'(LANES) : remQ[CNT_W-1:0];
endmodule

// File: rtl/vec_issue_top.sv
module vec_issue_top
  import vec_issue_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instrValid,
  input  logic [15:0]          instrWord,
  output logic                 instrStall,
  input  logic [15:0]          accelDone,
  output logic                 aluIssue,
  output logic [14:0]          aluWord,
  output logic                 accCmdValid,
  output logic [3:0]           accCmdUnit,
  output logic [9:0]           accCmdArg,
  output logic                 vecBusy,
  output logic [3:0]           vecOp,
  output logic [2:0]           vecPorts,
  output logic                 vecElemStrobe,
  output logic [6:0]           vecElemIdx,
  output logic [1:0]           vecElemCnt
);
  vecLaunch_t launch;
  logic       vecFree;

  vec_issue_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .instrValid(instrValid), .instrWord(instrWord), .accelDone(accelDone),
    .vecBusy(vecBusy), .vecFree(vecFree),
    .instrStall(instrStall), .launch(launch),
    .aluIssue(aluIssue), .aluWord(aluWord),
    .accCmdValid(accCmdValid), .accCmdUnit(accCmdUnit), .accCmdArg(accCmdArg)
  );

  vec_issue_datapath #(.LANES(2)) u_dp (
    .clk(clk), .rstN(rstN), .launch(launch),
    .vecBusy(vecBusy), .vecFree(vecFree),
    .vecOp(vecOp), .vecPorts(vecPorts),
    .vecElemStrobe(vecElemStrobe), .vecElemIdx(vecElemIdx), .vecElemCnt(vecElemCnt)
  );
endmodule

// File: rtl/vec_issue_chk.sv
module vec_issue_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [15:0] instrWord,
  input logic        instrStall,
  input logic [15:0] accelDone,
  input logic        aluIssue,
  input logic [14:0] aluWord,
  input logic        accCmdValid,
  input logic [3:0]  accCmdUnit,
  input logic        vecBusy,
  input logic        vecElemStrobe,
  input logic [1:0]  vecElemCnt
);
  logic isIdle, takeScalar, takeAccel, takeVec;
  assign isIdle     = !instrWord[15] && (instrWord[14:11] == 4'hF);
  assign takeScalar = instrValid && !instrStall && !instrWord[15] && !isIdle;
  assign takeAccel  = instrValid && !instrStall && (instrWord[15:14] == 2'b11);
  assign takeVec    = instrValid && !instrStall && (instrWord[15:14] == 2'b10);

  a_r11_stall_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !instrStall);

  a_r5_strobe_within_busy: assert property (@(posedge clk) disable iff (!rstN)
    vecElemStrobe |-> vecBusy);

  a_r5_pair_count: assert property (@(posedge clk) disable iff (!rstN)
    vecElemStrobe |-> (vecElemCnt != 2'd0 && vecElemCnt <= 2'd2));

  a_r4_busy_follows_launch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vecBusy) |-> $past(takeVec));

  a_r1_scalar_issue: assert property (@(posedge clk) disable iff (!rstN)
    takeScalar |=> (aluIssue && aluWord == $past(instrWord[14:0])));

  a_r2_accel_issue: assert property (@(posedge clk) disable iff (!rstN)
    takeAccel |=> (accCmdValid && accCmdUnit == $past(instrWord[13:10])));

  a_r6_no_stall_scalar_accel: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && (instrWord[15:14] == 2'b11 || (!instrWord[15] && !isIdle))) |-> !instrStall);

  a_r8_idle_vector_waits: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && isIdle && !instrWord[4] && vecBusy) |-> instrStall);

  a_r9_idle_accel_waits: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && isIdle && instrWord[4] && !accelDone[instrWord[3:0]]) |-> instrStall);
endmodule

bind vec_issue_top vec_issue_chk u_chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
  .instrStall(instrStall), .accelDone(accelDone), .aluIssue(aluIssue),
  .aluWord(aluWord), .accCmdValid(accCmdValid), .accCmdUnit(accCmdUnit),
  .vecBusy(vecBusy), .vecElemStrobe(vecElemStrobe), .vecElemCnt(vecElemCnt)
);

// File: tb/tb_vec_issue_top.sv
module tb_vec_issue_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic        instrStall;
  logic [15:0] accelDone = '0;
  logic        aluIssue;
  logic [14:0] aluWord;
  logic        accCmdValid;
  logic [3:0]  accCmdUnit;
  logic [9:0]  accCmdArg;
  logic        vecBusy;
  logic [3:0]  vecOp;
  logic [2:0]  vecPorts;
  logic        vecElemStrobe;
  logic [6:0]  vecElemIdx;
  logic [1:0]  vecElemCnt;

  vec_issue_top dut (.*);

  int checks = 0;
  int fails = 0;
  int busyCycles = 0;
  bit finished = 0;
  logic busyAtAccept;
  logic doneAtAccept;
  logic [14:0] aluQ[$];
  logic [13:0] accQ[$];
  logic [15:0] vecQ[$];
  logic [15:0] ev;
  logic [15:0] got;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expectations as the design produces results
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (vecBusy) busyCycles++;
      if (aluIssue) begin
        if (aluQ.size() == 0) chk(0, "R1 unexpected aluIssue (R8/R11)", int'(aluWord), -1);
        else begin
          ev[14:0] = aluQ.pop_front();
          chk(aluWord == ev[14:0], "R1 aluWord", int'(aluWord), int'(ev[14:0]));
        end
      end
      if (accCmdValid) begin
        got = {2'b0, accCmdUnit, accCmdArg};
        if (accQ.size() == 0) chk(0, "R2 unexpected accel command", int'(got), -1);
        else begin
          ev = {2'b0, accQ.pop_front()};
          chk(got == ev, "R2 accel unit/arg", int'(got), int'(ev));
        end
      end
      if (vecElemStrobe) begin
        got = {vecOp, vecPorts, vecElemIdx, vecElemCnt};
        if (vecQ.size() == 0) chk(0, "R5 unexpected element strobe", int'(got), -1);
        else begin
          ev = vecQ.pop_front();
          chk(got == ev, "R3/R5 op,ports,idx,cnt", int'(got), int'(ev));
        end
      end
    end
  end

  function automatic logic [15:0] vecWord(input int op, input int ports, input int n);
    return {2'b10, 4'(op), 3'(ports), 7'(n)};
  endfunction

  task automatic pushExpect(input logic [15:0] w);
    if (!w[15] && w[14:11] != 4'hF) aluQ.push_back(w[14:0]);
    else if (w[15:14] == 2'b11) accQ.push_back(w[13:0]);
    else if (w[15:14] == 2'b10) begin
      for (int k = 0; 2 * k < int'(w[6:0]); k++) begin
        int c = (int'(w[6:0]) - 2 * k >= 2) ? 2 : int'(w[6:0]) - 2 * k;
        vecQ.push_back({w[13:10], w[9:7], 7'(2 * k), 2'(c)});
      end
    end
  endtask

  task automatic issue(input logic [15:0] w, output int stalls);
    stalls = 0;
    @(negedge clk);
    instrValid = 1'b1;
    instrWord  = w;
    #1;
    while (instrStall) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    busyAtAccept = vecBusy;
    doneAtAccept = accelDone[w[3:0]];
    pushExpect(w);
    @(posedge clk);
    #1;
    instrValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (vecBusy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    int s;
    int b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!instrStall && !aluIssue && !accCmdValid && !vecBusy && !vecElemStrobe,
        "R10 outputs during reset", 1, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!vecBusy && !aluIssue && !accCmdValid && !vecElemStrobe, "R10 after reset", int'(vecBusy), 0);

    // R11: invalid words ignored
    instrWord = 16'h1234;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!instrStall, "R11 stall without valid", int'(instrStall), 0);
    end
    instrWord = 16'h8A05;
    repeat (3) @(negedge clk);
    chk(!vecBusy, "R11 vector word ignored when not valid", int'(vecBusy), 0);

    // R1, R2
    issue(16'h1234, s); chk(s == 0, "R1 scalar no stall", s, 0);
    issue(16'hC000 | (16'd5 << 10) | 16'h2A3, s); chk(s == 0, "R2 accel no stall", s, 0);
    waitIdle();

    // R4/R5: odd size
    b0 = busyCycles;
    issue(vecWord(3, 5, 7), s);
    waitIdle();
    chk(busyCycles - b0 == 4, "R4 busy length size 7", busyCycles - b0, 4);
    // size 0
    b0 = busyCycles;
    issue(vecWord(9, 1, 0), s);
    waitIdle();
    chk(busyCycles - b0 == 1, "R5 busy length size 0", busyCycles - b0, 1);
    // size 1
    b0 = busyCycles;
    issue(vecWord(2, 6, 1), s);
    waitIdle();
    chk(busyCycles - b0 == 1, "R4 busy length size 1", busyCycles - b0, 1);
    // size 127
    b0 = busyCycles;
    issue(vecWord(15, 7, 127), s);
    waitIdle();
    chk(busyCycles - b0 == 64, "R4 busy length size 127", busyCycles - b0, 64);

    // R6 and R8: overlap then IDLE on vector unit
    issue(vecWord(4, 2, 8), s);
    issue(16'h0ABC, s); chk(s == 0, "R6 scalar during vector", s, 0);
    issue(16'hC7FF, s); chk(s == 0, "R6 accel during vector", s, 0);
    issue(16'h7800, s);
    chk(s == 2, "R8 idle stall cycles", s, 2);
    chk(busyAtAccept == 1'b0, "R8 idle accepted only when not busy", int'(busyAtAccept), 0);
    waitIdle();

    // R7: back-to-back vectors
    b0 = busyCycles;
    issue(vecWord(1, 3, 6), s);
    issue(vecWord(6, 4, 4), s);
    chk(s == 2, "R7 vector stall cycles", s, 2);
    waitIdle();
    chk(busyCycles - b0 == 5, "R7 merged busy run", busyCycles - b0, 5);

    // R9: IDLE on accelerator 3, neighbour done already high
    accelDone = 16'h0004;
    fork
      issue(16'h7813, s);
      begin
        repeat (4) @(negedge clk);
        #2 accelDone[3] = 1'b1;
      end
    join
    chk(s >= 3, "R9 idle waits for own done bit", s, 3);
    chk(doneAtAccept == 1'b1, "R9 accepted with done high", int'(doneAtAccept), 1);
    accelDone = '0;
    waitIdle();

    chk(aluQ.size() == 0, "R1 pending scalar issues", aluQ.size(), 0);
    chk(accQ.size() == 0, "R2 pending accel commands", accQ.size(), 0);
    chk(vecQ.size() == 0, "R5 pending element strobes", vecQ.size(), 0);
    finished = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end
endmodule